// File: doc/BRIEF.md
# Power-Bounded Variable-Period Scan Clock Generator

This block drives the shift and capture clock of a scan test. It sets the length of each cycle on its own, so that power never rises above a programmed peak limit. Before the test, software computes the energy of every scan cycle and stores it in an external table. The block presents the index of the next cycle on `cycle_idx_o` and reads that cycle's energy back on `energy_i` in the same reference-clock cycle. The period is measured in ticks of the fast reference clock. It is the energy multiplied by a programmed fixed-point reciprocal of the power limit, rounded up to whole ticks. It is never shorter than a critical-path floor, and shift cycles and capture cycles each have their own floor. A fixed-period mode is also available. In that mode every cycle uses a single worst-case energy value, which gives a baseline for comparison.

The block also drives scan-enable. A chain-integrity pass of n_sff+4 shift cycles comes first. Each of the n_comb vectors then gets n_sff shift cycles followed by one capture cycle. A flush of n_sff shift cycles ends the test. When every cycle has been applied, the clock stops low and a done flag rises. The configuration inputs must stay stable from start until done, and n_sff must be at least 1.

Top module: `scan_vclk_gen`

## Requirements
- R1: In variable mode, the length of a cycle in reference ticks is the largest of ceil(E·recip / 2^FRAC_W), the floor for that cycle's kind, and 2. E is the table energy for that cycle's index. FRAC_W defaults to 8.
- R2: Shift cycles use `shift_floor_i` as their floor. Capture cycles use `capture_floor_i`. A floor below 2 acts as 2.
- R3: With `fixed_mode_i`=1, every cycle computes its length from `energy_max_i` in place of the table energy, with the same floors.
- R4: `scan_clk_o` is high for floor(P/2) ticks at the start of each P-tick cycle and low for the rest. A new cycle, and with it a new period, begins only on a rising edge.
- R5: `scan_en_o` is 1 during shift cycles and 0 during capture cycles, and it changes only together with a rising edge of `scan_clk_o`. The sequence is n_sff+4 shift cycles, then n_comb groups of (n_sff shift, 1 capture), then n_sff shift cycles.
- R6: After exactly (n_comb+2)·n_sff + n_comb + 4 cycles, `done_o` rises one tick after the last cycle ends and `scan_clk_o` stays low. This also holds for n_comb=0.
- R7: `cycle_idx_o` counts the cycles started so far. It rises by exactly one with each rising edge of `scan_clk_o`, and it is the table index whose energy is read for the next cycle.
- R8: `start_i` is ignored while a test is running and after done. `done_o` stays high until reset.
- R9: While reset is active and afterwards until a start, `scan_clk_o`, `scan_en_o` and `done_o` are 0 and `cycle_idx_o` is 0.
- R10: For the same table and limit, the total test time in variable mode is no longer than in fixed mode whenever `energy_max_i` bounds every table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts the test when idle |
| fixed_mode_i | input | 1 | 1: fixed worst-case period for every cycle |
| recip_pmax_i | input | R_W | Reciprocal of the power limit, FRAC_W fraction bits |
| energy_i | input | E_W | Table energy at index `cycle_idx_o` |
| energy_max_i | input | E_W | Worst-case energy used in fixed mode |
| shift_floor_i | input | P_W | Minimum period for shift cycles, in ticks |
| capture_floor_i | input | P_W | Minimum period for capture cycles, in ticks |
| n_sff_i | input | SFF_W | Length of the longest chain |
| n_comb_i | input | COMB_W | Number of test vectors |
| scan_clk_o | output | 1 | Variable-period scan clock |
| scan_en_o | output | 1 | Scan-enable, 1 during shift |
| done_o | output | 1 | All cycles applied, clock stopped |
| cycle_idx_o | output | CNT_W | Cycles started, which is also the next table index |

## Verification
Start sampled at reference edge k gives a high `scan_clk_o`, the new `cycle_idx_o` and the matching `scan_en_o` right after edge k. Each cycle of P ticks holds for P samples, and the next rising edge follows edge k+P. `done_o` appears one tick after the last low sample. The bench drives on falling edges and samples once per falling edge. It counts high and total samples between two observed rising edges and compares them with the period and the high phase it computes from its own copy of the energy table and the formula. It checks `scan_en_o` and the index on the first sample of each cycle.

// File: rtl/scan_vclk_pkg.sv
package scan_vclk_pkg;
  typedef enum logic [1:0] {
    SEG_CHAIN,
    SEG_SHIFT,
    SEG_CAPT,
    SEG_FLUSH
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } run_state_e;

  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/scan_vclk_seq.sv
module scan_vclk_seq
  import scan_vclk_pkg::*;
#(
  parameter int SFF_W  = 16,
  parameter int COMB_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [SFF_W-1:0]  n_sff_i,
  input  logic [COMB_W-1:0] n_comb_i,
  output logic              shift_o
);
  localparam int SC_W = SFF_W + 1;

  seg_e              seg_q;
  logic [SC_W-1:0]   seg_cnt_q;
  logic [COMB_W-1:0] vec_q;
  logic [SC_W-1:0]   chain_last;
  logic [SC_W-1:0]   sff_last;
  logic [COMB_W-1:0] comb_last;

  assign chain_last = {1'b0, n_sff_i} + SC_W'(3);
  assign sff_last   = {1'b0, n_sff_i} - SC_W'(1);
  assign comb_last  = n_comb_i - COMB_W'(1);
  assign shift_o    = (seg_q != SEG_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q     <= SEG_CHAIN;
      seg_cnt_q <= '0;
      vec_q     <= '0;
    end else if (clear_i) begin
      seg_q     <= SEG_CHAIN;
      seg_cnt_q <= '0;
      vec_q     <= '0;
    end else if (adv_i) begin
      unique case (seg_q)
        SEG_CHAIN: begin
          if (seg_cnt_q == chain_last) begin
            seg_cnt_q <= '0;
            seg_q     <= (n_comb_i == '0) ? SEG_FLUSH : SEG_SHIFT;
          end else begin
            seg_cnt_q <= seg_cnt_q + SC_W'(1);
          end
        end
        SEG_SHIFT: begin
          if (seg_cnt_q == sff_last) begin
            seg_cnt_q <= '0;
            seg_q     <= SEG_CAPT;
          end else begin
            seg_cnt_q <= seg_cnt_q + SC_W'(1);
          end
        end
        SEG_CAPT: begin
          vec_q <= vec_q + COMB_W'(1);
          seg_q <= (vec_q == comb_last) ? SEG_FLUSH : SEG_SHIFT;
        end
        default: seg_cnt_q <= seg_cnt_q + SC_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/scan_vclk_period.sv
module scan_vclk_period
  import scan_vclk_pkg::*;
#(
  parameter int E_W    = 16,
  parameter int R_W    = 16,
  parameter int FRAC_W = 8,
  parameter int P_W    = 16
) (
  input  logic             fixed_mode_i,
  input  logic             shift_i,
  input  logic [E_W-1:0]   energy_i,
  input  logic [E_W-1:0]   energy_max_i,
  input  logic [R_W-1:0]   recip_i,
  input  logic [P_W-1:0]   shift_floor_i,
  input  logic [P_W-1:0]   capture_floor_i,
  output logic [P_W-1:0]   period_o
);
  localparam int PROD_W = E_W + R_W;
  localparam int TICK_W = PROD_W + 1 - FRAC_W;
  localparam logic [PROD_W:0] ROUND_UP = {{(PROD_W + 1 - FRAC_W){1'b0}}, {FRAC_W{1'b1}}};

  logic [E_W-1:0]    e_sel;
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   prod_rnd;
  logic [TICK_W-1:0] ticks;
  logic [P_W-1:0]    ticks_p;
  logic [P_W-1:0]    floor_sel;
  logic [P_W-1:0]    floor_min;

  assign e_sel    = fixed_mode_i ? energy_max_i : energy_i;
  assign prod     = PROD_W'(e_sel) * PROD_W'(recip_i);
  assign prod_rnd = {1'b0, prod} + ROUND_UP;
  assign ticks    = prod_rnd[PROD_W:FRAC_W];

  generate
    if (TICK_W > P_W) begin : g_sat
      always_comb begin
        if (|ticks[TICK_W-1:P_W]) ticks_p = '1;
        else                      ticks_p = ticks[P_W-1:0];
      end
    end else begin : g_wide
      assign ticks_p = P_W'(ticks);
    end
  endgenerate

  assign floor_sel = shift_i ? shift_floor_i : capture_floor_i;
  assign floor_min = (floor_sel < P_W'(MIN_PERIOD)) ? P_W'(MIN_PERIOD) : floor_sel;
  assign period_o  = (ticks_p > floor_min) ? ticks_p : floor_min;
endmodule

// File: rtl/scan_vclk_clkgen.sv
module scan_vclk_clkgen #(
  parameter int P_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           stop_i,
  input  logic [P_W-1:0] period_i,
  output logic           scan_clk_o,
  output logic           cyc_end_o
);
  logic [P_W-1:0] period_q;
  logic [P_W-1:0] high_q;
  logic [P_W-1:0] ph_q;
  logic [P_W-1:0] ph_nx;
  logic           active_q;
  logic           clk_q;

  assign ph_nx      = ph_q + P_W'(1);
  assign cyc_end_o  = active_q && (ph_q == period_q - P_W'(1));
  assign scan_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      high_q   <= '0;
      ph_q     <= '0;
      active_q <= 1'b0;
      clk_q    <= 1'b0;
    end else if (load_i) begin
      period_q <= period_i;
      high_q   <= period_i >> 1;
      ph_q     <= '0;
      active_q <= 1'b1;
      clk_q    <= 1'b1;
    end else if (stop_i) begin
      ph_q     <= '0;
      active_q <= 1'b0;
      clk_q    <= 1'b0;
    end else if (active_q) begin
      ph_q  <= ph_nx;
      clk_q <= (ph_nx < high_q);
    end
  end
endmodule

// File: rtl/scan_vclk_gen.sv
module scan_vclk_gen
  import scan_vclk_pkg::*;
#(
  parameter int E_W    = 16,
  parameter int R_W    = 16,
  parameter int FRAC_W = 8,
  parameter int P_W    = 16,
  parameter int SFF_W  = 16,
  parameter int COMB_W = 16,
  parameter int CNT_W  = SFF_W + COMB_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fixed_mode_i,
  input  logic [R_W-1:0]    recip_pmax_i,
  input  logic [E_W-1:0]    energy_i,
  input  logic [E_W-1:0]    energy_max_i,
  input  logic [P_W-1:0]    shift_floor_i,
  input  logic [P_W-1:0]    capture_floor_i,
  input  logic [SFF_W-1:0]  n_sff_i,
  input  logic [COMB_W-1:0] n_comb_i,
  output logic              scan_clk_o,
  output logic              scan_en_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cycle_idx_o
);
  run_state_e       st_q;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] total;
  logic             se_q;
  logic             shift_kind;
  logic [P_W-1:0]   period;
  logic             cyc_end;
  logic             load;
  logic             stop;
  logic             idle;

  assign idle  = (st_q == ST_IDLE);
  assign total = (CNT_W'(n_comb_i) + CNT_W'(2)) * CNT_W'(n_sff_i)
               + CNT_W'(n_comb_i) + CNT_W'(4);
  assign load  = (idle && start_i) || (cyc_end && (cyc_q != total));
  assign stop  = cyc_end && (cyc_q == total);

  scan_vclk_seq #(
    .SFF_W (SFF_W),
    .COMB_W(COMB_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (idle && !start_i),
    .adv_i   (load),
    .n_sff_i (n_sff_i),
    .n_comb_i(n_comb_i),
    .shift_o (shift_kind)
  );

  scan_vclk_period #(
    .E_W   (E_W),
    .R_W   (R_W),
    .FRAC_W(FRAC_W),
    .P_W   (P_W)
  ) u_period (
    .fixed_mode_i   (fixed_mode_i),
    .shift_i        (shift_kind),
    .energy_i       (energy_i),
    .energy_max_i   (energy_max_i),
    .recip_i        (recip_pmax_i),
    .shift_floor_i  (shift_floor_i),
    .capture_floor_i(capture_floor_i),
    .period_o       (period)
  );

  scan_vclk_clkgen #(
    .P_W(P_W)
  ) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .stop_i    (stop),
    .period_i  (period),
    .scan_clk_o(scan_clk_o),
    .cyc_end_o (cyc_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
      se_q  <= 1'b0;
    end else begin
      if (load) begin
        cyc_q <= cyc_q + CNT_W'(1);
        se_q  <= shift_kind;
        st_q  <= ST_RUN;
      end else if (stop) begin
        st_q <= ST_DONE;
      end
    end
  end

  assign scan_en_o   = se_q;
  assign done_o      = (st_q == ST_DONE);
  assign cycle_idx_o = cyc_q;
endmodule

// File: rtl/scan_vclk_gen_chk.sv
module scan_vclk_gen_chk #(
  parameter int SFF_W  = 16,
  parameter int COMB_W = 16,
  parameter int CNT_W  = SFF_W + COMB_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SFF_W-1:0]  n_sff_i,
  input logic [COMB_W-1:0] n_comb_i,
  input logic              scan_clk_o,
  input logic              scan_en_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  cycle_idx_o
);
  logic [CNT_W-1:0] exp_total;
  assign exp_total = (CNT_W'(n_comb_i) + CNT_W'(2)) * CNT_W'(n_sff_i)
                   + CNT_W'(n_comb_i) + CNT_W'(4);

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R8
  AST_DONE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scan_clk_o); // R6
  AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cycle_idx_o == exp_total); // R6
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scan_clk_o) |-> cycle_idx_o == $past(cycle_idx_o) + CNT_W'(1)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(scan_clk_o) |-> $stable(cycle_idx_o)); // R7
  AST_SE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scan_en_o) |-> $rose(scan_clk_o)); // R5
endmodule

bind scan_vclk_gen scan_vclk_gen_chk #(
  .SFF_W (SFF_W),
  .COMB_W(COMB_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .n_sff_i    (n_sff_i),
  .n_comb_i   (n_comb_i),
  .scan_clk_o (scan_clk_o),
  .scan_en_o  (scan_en_o),
  .done_o     (done_o),
  .cycle_idx_o(cycle_idx_o)
);

// File: tb/scan_vclk_gen_tb.sv
module scan_vclk_gen_tb;
  localparam int CNT_W = 34;
  localparam int LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        fixed_mode_i = 1'b0;
  logic [15:0] recip_pmax_i = '0;
  logic [15:0] energy_i;
  logic [15:0] energy_max_i = '0;
  logic [15:0] shift_floor_i = '0;
  logic [15:0] capture_floor_i = '0;
  logic [15:0] n_sff_i = 16'd1;
  logic [15:0] n_comb_i = '0;
  logic        scan_clk_o;
  logic        scan_en_o;
  logic        done_o;
  logic [CNT_W-1:0] cycle_idx_o;

  int chk = 0;
  int err = 0;
  longint ticks_var = 0;
  longint ticks_fix = 0;

  always #2 clk_i = ~clk_i;

  scan_vclk_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fixed_mode_i(fixed_mode_i),
    .recip_pmax_i(recip_pmax_i), .energy_i(energy_i), .energy_max_i(energy_max_i),
    .shift_floor_i(shift_floor_i), .capture_floor_i(capture_floor_i),
    .n_sff_i(n_sff_i), .n_comb_i(n_comb_i), .scan_clk_o(scan_clk_o),
    .scan_en_o(scan_en_o), .done_o(done_o), .cycle_idx_o(cycle_idx_o)
  );

  function automatic int tbl_energy(longint i);
    return int'((i * 53 + 7) % 61);
  endfunction

  assign energy_i = 16'(tbl_energy(longint'(cycle_idx_o)));

  function automatic bit exp_shift(int idx);
    int s = int'(n_sff_i);
    int c = int'(n_comb_i);
    int j;
    if (idx < s + 4) return 1'b1;
    j = idx - (s + 4);
    if (j < c * (s + 1)) return (j % (s + 1)) != s;
    return 1'b1;
  endfunction

  function automatic int exp_period(int idx);
    longint e = fixed_mode_i ? longint'(energy_max_i) : longint'(tbl_energy(idx));
    longint t = (e * longint'(recip_pmax_i) + 255) / 256;
    longint f = exp_shift(idx) ? longint'(shift_floor_i) : longint'(capture_floor_i);
    if (f < 2) f = 2;
    if (t > 65535) t = 65535;
    return int'((t > f) ? t : f);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic close_cycle(int idx, int cnt, int hi);
    int p = exp_period(idx);
    string tag = fixed_mode_i ? "R3 period" : (exp_shift(idx) ? "R1 period" : "R2 capture period");
    check(cnt == p, tag, cnt, p);
    check(hi == p / 2, "R4 high phase", hi, p / 2);
  endtask

  task automatic run_cfg(bit fx, int sff, int comb, int recip, int emax, int sf, int cf,
                         bit poke_start, output longint used);
    int idx = -1;
    int cnt = 0;
    int hi = 0;
    bit prev = 1'b0;
    int t = 0;
    longint total = longint'((comb + 2) * sff + comb + 4);
    longint idx_end;
    used = 0;
    rst_ni = 1'b0;
    fixed_mode_i = fx;
    n_sff_i = 16'(sff);
    n_comb_i = 16'(comb);
    recip_pmax_i = 16'(recip);
    energy_max_i = 16'(emax);
    shift_floor_i = 16'(sf);
    capture_floor_i = 16'(cf);
    repeat (3) @(negedge clk_i);
    check(!scan_clk_o && !scan_en_o && !done_o && cycle_idx_o == 0, "R9 reset state",
          longint'({scan_clk_o, scan_en_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(!scan_clk_o && cycle_idx_o == 0, "R9 idle before start", longint'(cycle_idx_o), 0);
    start_i = 1'b1;
    forever begin
      @(negedge clk_i);
      t++;
      start_i = poke_start && (t == 40 || t == 41);
      if (t > LIMIT) begin
        check(1'b0, "watchdog", t, LIMIT);
        break;
      end
      if (done_o) begin
        if (idx >= 0) close_cycle(idx, cnt, hi);
        break;
      end
      if (scan_clk_o && !prev) begin
        if (idx >= 0) close_cycle(idx, cnt, hi);
        idx++;
        cnt = 1;
        hi = 1;
        check(scan_en_o == exp_shift(idx), "R5 scan enable", scan_en_o, exp_shift(idx));
        check(cycle_idx_o == CNT_W'(idx + 1), "R7 cycle index", longint'(cycle_idx_o), idx + 1);
      end else begin
        cnt++;
        hi += int'(scan_clk_o);
      end
      prev = scan_clk_o;
      if (idx >= 0) used++;
    end
    start_i = 1'b0;
    check(longint'(idx + 1) == total, "R6 cycles applied", idx + 1, total);
    check(longint'(cycle_idx_o) == total, "R6 final count", longint'(cycle_idx_o), total);
    idx_end = longint'(cycle_idx_o);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      start_i = (k == 5);
      check(done_o && !scan_clk_o && longint'(cycle_idx_o) == idx_end,
            "R8 stays done", longint'({done_o, scan_clk_o}), 2);
    end
    start_i = 1'b0;
  endtask

  task automatic test_variable();
    longint u;
    run_cfg(1'b0, 3, 2, 384, 60, 4, 9, 1'b1, u);
    ticks_var = u;
  endtask

  task automatic test_fixed();
    longint u;
    run_cfg(1'b1, 3, 2, 384, 60, 4, 9, 1'b0, u);
    ticks_fix = u;
    check(ticks_var <= ticks_fix, "R10 variable time not longer", ticks_var, ticks_fix);
  endtask

  task automatic test_no_vectors();
    longint u;
    run_cfg(1'b0, 2, 0, 200, 60, 3, 3, 1'b0, u);
  endtask

  task automatic test_floor_split();
    longint u;
    run_cfg(1'b0, 2, 3, 0, 60, 5, 11, 1'b0, u);
  endtask

  task automatic test_floor_clamp();
    longint u;
    run_cfg(1'b0, 1, 3, 0, 60, 0, 1, 1'b0, u);
  endtask

  task automatic test_odd_recip();
    longint u;
    run_cfg(1'b0, 4, 1, 77, 60, 2, 2, 1'b0, u);
  endtask

  initial begin
    test_variable();
    test_fixed();
    test_no_vectors();
    test_floor_split();
    test_floor_clamp();
    test_odd_recip();
    $display("CHECKS %0d ERRORS %0d", chk, err);
    $finish;
  end
endmodule